// File: doc/BRIEF.md
# Three-Bank Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, organised as three banks of 32, and presents them to a processor as two request outputs: a normal class and a fast class. Each line carries a configuration word that holds a 6-bit priority and a routing bit. The routing bit chooses the class that the line feeds. Software uses a 32-bit register port to mask lines, to raise and withdraw software interrupts, to view pending state, to read the winning line code for each class, and to re-arm each class once it has handled the request.

Arbitration freezes the winner. While a class is armed, the controller looks for an unmasked pending line of that class, provided the global mask is clear. When it finds one, it latches the code of the best line, drives the class output high and disarms the class. The output and the code then stay fixed until software writes the re-arm bit for that class. That write drops the output, and the search runs again on the next cycle. The lowest priority value wins. When priorities are equal, the higher line number wins.

The register port is word-addressed: `bus_addr` carries byte-address bits [11:2]. Read data is registered.

Top module: `lic_ctrl`

## Requirements
- R1: After reset, both class outputs are low and every bank mask (byte offsets 0x84, 0xA4, 0xC4) reads 0xFFFFFFFF. The pending views, the software bits and the codes read 0. Offset 0x00 reads 0x21 and offset 0x14 reads 1.
- R2: Bank b sits at byte offset 0x80 + 0x20·b. A rising input sets its bit in the raw view (+0x00) and in the pending state. The class views read pending AND NOT mask, restricted to normal-routed lines (+0x18) or fast-routed lines (+0x1C).
- R3: When any input of a bank falls, that bank's pending state becomes its current inputs OR its software bits.
- R4: Writing +0x04 loads the mask. Writing +0x08 clears the mask bits written as one, and writing +0x0C sets them. Both aliases read 0.
- R5: Writing +0x10 ORs the data into the software bits and into pending, and a read of +0x10 returns the software bits. Writing +0x14 clears the software bits written as one and then loads pending with the new software bits AND the inputs.
- R6: The winner is the unmasked pending line of the class with the lowest priority value; a tie goes to the higher line number. Its code is its line number (bank·32 + bit), read at 0x40 for the normal class and at 0x44 for the fast class. The output rises one cycle after the pending state that it reflects.
- R7: Once a class output is high, it and its code hold until byte offset 0x48 is written with bit 0 (normal class) or bit 1 (fast class) set. That write drops the output, and a new winner is taken on the following cycle.
- R8: The configuration word of line n is at 0x100 + 4·n. Bits [7:2] hold the priority and bit 0 routes the line to the fast class. The word reads back with bit 1 as zero.
- R9: Bit 2 of 0x48 is a global mask. While it is set, neither output can rise. It reads back in bit 2.
- R10: Accesses to bank index 3 (0xE0–0xFF) read 0 and change no state.
- R11: Writes to 0x00, 0x14, 0x40, 0x44 and the raw and class pending views of each bank are ignored.
- R12: Bit 0 of 0x10 stores an autoidle bit that reads back. 0x50 stores a 2-bit idle field. 0x14 always reads 1.
- R13: Writing 0x10 with bit 1 set restores every state element to its reset value on the next clock edge, with the masks set to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 96 | Level interrupt inputs, line n on bit n |
| bus_sel | input | 1 | Register access request for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_norm | output | 1 | Normal-class request |
| irq_fast | output | 1 | Fast-class request |

## Verification
The input levels are registered at the edge after they change, and the pending state is registered at that same edge. The raw and pending views therefore reflect the new level from the next read onward. A class output and its code register change one edge later again. A register write takes effect at the edge that closes the access. Read data appears at that same edge. A re-arm drops the output at the write edge and latches a new winner on the next edge. A soft reset clears state one edge after its write. The bench drives inputs after the falling edge and samples 1 ns after the rising edge. It waits exactly these edge counts before each comparison, so it catches a result that arrives early as well as one that arrives late.

// File: rtl/lic_pkg.sv
// Shared constants and register offset codes for the level interrupt controller.
// Assumes a 32-bit data path and a byte map of 4 KiB, decoded on word addresses.
package lic_pkg;

    localparam int DEF_BANK_W  = 32;
    localparam int DEF_PRIO_W  = 6;
    localparam int LINE_BASE_W = 64;   // 0x100 >> 2, first line configuration word

    // Word offsets inside one bank window (byte offset >> 2)
    typedef enum logic [2:0] {
        BK_RAW   = 3'd0,
        BK_MASK  = 3'd1,
        BK_MCLR  = 3'd2,
        BK_MSET  = 3'd3,
        BK_SSET  = 3'd4,
        BK_SCLR  = 3'd5,
        BK_PNORM = 3'd6,
        BK_PFAST = 3'd7
    } bank_off_e;

    // Word offsets of the global registers (byte offset >> 2)
    typedef enum logic [4:0] {
        G_REV    = 5'd0,
        G_SYSCFG = 5'd4,
        G_STATUS = 5'd5,
        G_CODE_N = 5'd16,
        G_CODE_F = 5'd17,
        G_CTRL   = 5'd18,
        G_IDLE   = 5'd20
    } glob_off_e;

endpackage

// File: rtl/lic_bank.sv
// One bank of level lines: input sampling, pending, software bits and mask.
// Assumes the lines are level-only; the fast-routing bits come from the line configuration.
module lic_bank #(
    parameter int W = lic_pkg::DEF_BANK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        irq_lvl,
    input  logic [W-1:0]        fast,
    input  logic                wr_en,
    input  lic_pkg::bank_off_e  wr_off,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        raw,
    output logic [W-1:0]        mask,
    output logic [W-1:0]        swi,
    output logic [W-1:0]        cand_norm,
    output logic [W-1:0]        cand_fast
);
    import lic_pkg::*;

    logic [W-1:0] in_q, pend_q, swi_q, mask_q;
    logic [W-1:0] rise, fall, pend_evt;
    logic [W-1:0] pend_n, swi_n, mask_n;

    // Input events: a rise adds its bit, any fall rebuilds pending from the levels and software bits
    always_comb begin
        rise     = irq_lvl & ~in_q;
        fall     = in_q & ~irq_lvl;
        pend_evt = (|fall) ? (irq_lvl | swi_q) : (pend_q | rise);
    end

    // Register writes are applied on top of the input events of the same cycle
    always_comb begin
        pend_n = pend_evt;
        swi_n  = swi_q;
        mask_n = mask_q;
        if (wr_en) begin
            case (wr_off)
                BK_MASK: mask_n = wdata;
                BK_MCLR: mask_n = mask_q & ~wdata;
                BK_MSET: mask_n = mask_q | wdata;
                BK_SSET: begin
                    swi_n  = swi_q | wdata;
                    pend_n = pend_evt | swi_n;
                end
                BK_SCLR: begin
                    swi_n  = swi_q & ~wdata;
                    pend_n = swi_n & irq_lvl;
                end
                default: ;
            endcase
        end
    end

    // State registers of the bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            pend_q <= '0;
            swi_q  <= '0;
            mask_q <= '1;
        end else begin
            in_q   <= irq_lvl;
            pend_q <= pend_n;
            swi_q  <= swi_n;
            mask_q <= mask_n;
        end
    end

    // Views toward the register port and the arbiters
    always_comb begin
        raw       = in_q;
        mask      = mask_q;
        swi       = swi_q;
        cand_norm = pend_q & ~mask_q & ~fast;
        cand_fast = pend_q & ~mask_q & fast;
    end

endmodule

// File: rtl/lic_linecfg.sv
// Per-line configuration store: a priority and a fast-routing bit for every line.
// Assumes the caller qualifies the write and read indices to the line range.
module lic_linecfg #(
    parameter int NLINE  = 96,
    parameter int PRIO_W = lic_pkg::DEF_PRIO_W,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(NLINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [PRIO_W-1:0] wr_prio,
    input  logic              wr_fast,
    output logic [DATA_W-1:0] rd_word,
    output logic [PRIO_W-1:0] prio_q [NLINE],
    output logic [NLINE-1:0]  fast_q
);

    // Configuration registers, cleared to priority 0 and normal routing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINE; i++) prio_q[i] <= '0;
            fast_q <= '0;
        end else if (wr_en) begin
            prio_q[idx] <= wr_prio;
            fast_q[idx] <= wr_fast;
        end
    end

    // Readback word: priority in [PRIO_W+1:2], routing in bit 0
    always_comb begin
        rd_word = {{(DATA_W-PRIO_W-2){1'b0}}, prio_q[idx], 1'b0, fast_q[idx]};
    end

endmodule

// File: rtl/lic_arbiter.sv
// Frozen-winner arbiter for one class: a comparison tree picks the best candidate,
// and the code and request are latched once per arming. Assumes that rearm is a one-cycle pulse.
module lic_arbiter #(
    parameter int NLINE  = 96,
    parameter int PRIO_W = lic_pkg::DEF_PRIO_W,
    parameter int CODE_W = $clog2(NLINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINE-1:0]  cand,
    input  logic [PRIO_W-1:0] prio [NLINE],
    input  logic              gmask,
    input  logic              rearm,
    output logic              irq,
    output logic [CODE_W-1:0] code
);
    localparam int LEAVES = 1 << CODE_W;

    logic              win_vld;
    logic [CODE_W-1:0] win_code;
    logic              armed_q;

    // Balanced tree: a node keeps its right child on equal priority, so the higher line wins ties
    always_comb begin : tree
        logic              nv [2*LEAVES];
        logic [PRIO_W-1:0] np [2*LEAVES];
        logic [CODE_W-1:0] nc [2*LEAVES];
        logic              take_r;
        nv[0] = 1'b0;
        np[0] = '0;
        nc[0] = '0;
        for (int i = 0; i < NLINE; i++) begin
            nv[LEAVES+i] = cand[i];
            np[LEAVES+i] = prio[i];
            nc[LEAVES+i] = CODE_W'(i);
        end
        for (int i = NLINE; i < LEAVES; i++) begin
            nv[LEAVES+i] = 1'b0;
            np[LEAVES+i] = '0;
            nc[LEAVES+i] = '0;
        end
        for (int n = LEAVES - 1; n >= 1; n--) begin
            take_r = nv[2*n+1] && (!nv[2*n] || (np[2*n+1] <= np[2*n]));
            nv[n]  = nv[2*n] | nv[2*n+1];
            np[n]  = take_r ? np[2*n+1] : np[2*n];
            nc[n]  = take_r ? nc[2*n+1] : nc[2*n];
        end
        win_vld  = nv[1];
        win_code = nc[1];
    end

    // Arm, latch and release sequencing for the class request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            irq     <= 1'b0;
            code    <= '0;
        end else if (rearm) begin
            armed_q <= 1'b1;
            irq     <= 1'b0;
        end else if (armed_q && win_vld && !gmask) begin
            armed_q <= 1'b0;
            irq     <= 1'b1;
            code    <= win_code;
        end
    end

endmodule

// File: rtl/lic_ctrl.sv
// Top of the level interrupt controller: address decode, global registers,
// soft reset, read mux, and the bank, configuration and arbiter instances.
// Assumes single-cycle accesses with word addresses; read data is registered.
module lic_ctrl #(
    parameter int         NBANK  = 3,
    parameter int         BANK_W = lic_pkg::DEF_BANK_W,
    parameter int         PRIO_W = lic_pkg::DEF_PRIO_W,
    parameter int         ADDR_W = 12,
    parameter logic [7:0] REV    = 8'h21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NBANK*BANK_W-1:0] irq_in,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:2]       bus_addr,
    input  logic [BANK_W-1:0]       bus_wdata,
    output logic [BANK_W-1:0]       bus_rdata,
    output logic                    irq_norm,
    output logic                    irq_fast
);
    import lic_pkg::*;

    localparam int NLINE  = NBANK * BANK_W;
    localparam int DATA_W = BANK_W;
    localparam int IDX_W  = $clog2(NLINE);
    localparam int CODE_W = $clog2(NLINE);
    localparam int WORD_W = ADDR_W - 2;
    localparam int BIDX_W = 2;

    logic              srst_q, core_rst_n;
    logic              autoidle_q, gmask_q;
    logic [1:0]        idle_q;
    logic              is_glob, is_bank, is_line, bank_ok;
    logic [BIDX_W-1:0] bank_idx;
    logic [4:0]        glob_off;
    logic [WORD_W-1:0] line_off;
    logic              wr_glob, wr_line, rearm_n, rearm_f;
    logic [DATA_W-1:0] rd_val, line_rd;
    logic [CODE_W-1:0] code_norm, code_fast;
    logic [NLINE-1:0]  cand_norm_all, cand_fast_all, fast_all;
    logic [PRIO_W-1:0] prio_all [NLINE];
    logic [BANK_W-1:0] raw_b [NBANK];
    logic [BANK_W-1:0] mask_b [NBANK];
    logic [BANK_W-1:0] swi_b [NBANK];

    // Address decode into the global, bank and line regions
    always_comb begin
        is_glob  = bus_addr[ADDR_W-1:7] == '0;
        is_bank  = bus_addr[ADDR_W-1:7] == (ADDR_W-7)'(1);
        bank_idx = bus_addr[6:5];
        bank_ok  = int'(bank_idx) < NBANK;
        glob_off = bus_addr[6:2];
        line_off = bus_addr - WORD_W'(LINE_BASE_W);
        is_line  = (bus_addr >= WORD_W'(LINE_BASE_W)) && (line_off < WORD_W'(NLINE));
        wr_glob  = bus_sel && bus_wr && is_glob;
        wr_line  = bus_sel && bus_wr && is_line;
        rearm_n  = wr_glob && (glob_off == G_CTRL) && bus_wdata[0];
        rearm_f  = wr_glob && (glob_off == G_CTRL) && bus_wdata[1];
    end

    // Soft reset request: a one-cycle pulse that resets all state on the next edge
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= wr_glob && (glob_off == G_SYSCFG) && bus_wdata[1];
    end

    assign core_rst_n = rst_n && !srst_q;

    // Global configuration registers
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            autoidle_q <= 1'b0;
            gmask_q    <= 1'b0;
            idle_q     <= '0;
        end else if (wr_glob) begin
            if (glob_off == G_SYSCFG) autoidle_q <= bus_wdata[0];
            if (glob_off == G_CTRL)   gmask_q    <= bus_wdata[2];
            if (glob_off == G_IDLE)   idle_q     <= bus_wdata[1:0];
        end
    end

    // One bank instance for each group of BANK_W lines
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        lic_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (core_rst_n),
            .irq_lvl   (irq_in[b*BANK_W +: BANK_W]),
            .fast      (fast_all[b*BANK_W +: BANK_W]),
            .wr_en     (bus_sel && bus_wr && is_bank && (bank_idx == BIDX_W'(b))),
            .wr_off    (bank_off_e'(bus_addr[4:2])),
            .wdata     (bus_wdata),
            .raw       (raw_b[b]),
            .mask      (mask_b[b]),
            .swi       (swi_b[b]),
            .cand_norm (cand_norm_all[b*BANK_W +: BANK_W]),
            .cand_fast (cand_fast_all[b*BANK_W +: BANK_W])
        );
    end

    lic_linecfg #(.NLINE(NLINE), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .wr_en   (wr_line),
        .idx     (line_off[IDX_W-1:0]),
        .wr_prio (bus_wdata[PRIO_W+1:2]),
        .wr_fast (bus_wdata[0]),
        .rd_word (line_rd),
        .prio_q  (prio_all),
        .fast_q  (fast_all)
    );

    lic_arbiter #(.NLINE(NLINE), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_arb_norm (
        .clk   (clk),
        .rst_n (core_rst_n),
        .cand  (cand_norm_all),
        .prio  (prio_all),
        .gmask (gmask_q),
        .rearm (rearm_n),
        .irq   (irq_norm),
        .code  (code_norm)
    );

    lic_arbiter #(.NLINE(NLINE), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_arb_fast (
        .clk   (clk),
        .rst_n (core_rst_n),
        .cand  (cand_fast_all),
        .prio  (prio_all),
        .gmask (gmask_q),
        .rearm (rearm_f),
        .irq   (irq_fast),
        .code  (code_fast)
    );

    // Read multiplexer over every readable register
    always_comb begin
        rd_val = '0;
        if (is_glob) begin
            case (glob_off)
                G_REV:    rd_val = {{(DATA_W-8){1'b0}}, REV};
                G_SYSCFG: rd_val = {{(DATA_W-1){1'b0}}, autoidle_q};
                G_STATUS: rd_val = {{(DATA_W-1){1'b0}}, 1'b1};
                G_CODE_N: rd_val = {{(DATA_W-CODE_W){1'b0}}, code_norm};
                G_CODE_F: rd_val = {{(DATA_W-CODE_W){1'b0}}, code_fast};
                G_CTRL:   rd_val = {{(DATA_W-3){1'b0}}, gmask_q, 2'b00};
                G_IDLE:   rd_val = {{(DATA_W-2){1'b0}}, idle_q};
                default:  rd_val = '0;
            endcase
        end else if (is_bank && bank_ok) begin
            for (int b = 0; b < NBANK; b++) begin
                if (bank_idx == BIDX_W'(b)) begin
                    case (bank_off_e'(bus_addr[4:2]))
                        BK_RAW:   rd_val = raw_b[b];
                        BK_MASK:  rd_val = mask_b[b];
                        BK_SSET:  rd_val = swi_b[b];
                        BK_PNORM: rd_val = cand_norm_all[b*BANK_W +: BANK_W];
                        BK_PFAST: rd_val = cand_fast_all[b*BANK_W +: BANK_W];
                        default:  rd_val = '0;
                    endcase
                end
            end
        end else if (is_line) begin
            rd_val = line_rd;
        end
    end

    // Registered read data, cleared between reads
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_val;
        else                        bus_rdata <= '0;
    end

endmodule

// File: rtl/lic_ctrl_chk.sv
// Property checker for lic_ctrl, attached with the bind below.
// Observes the bus, the class outputs, the latched codes, the global mask and the soft-reset pulse.
module lic_ctrl_chk #(
    parameter int         ADDR_W = 12,
    parameter int         DATA_W = 32,
    parameter int         CODE_W = 7,
    parameter int         NLINE  = 96,
    parameter logic [7:0] REV    = 8'h21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:2] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_norm,
    input logic              irq_fast,
    input logic [CODE_W-1:0] code_norm,
    input logic [CODE_W-1:0] code_fast,
    input logic              gmask,
    input logic              srst
);
    logic wr_ctrl, rd_rev, rd_stat;
    assign wr_ctrl = bus_sel && bus_wr  && (bus_addr == (ADDR_W-2)'(18));
    assign rd_rev  = bus_sel && !bus_wr && (bus_addr == (ADDR_W-2)'(0));
    assign rd_stat = bus_sel && !bus_wr && (bus_addr == (ADDR_W-2)'(5));

    p_frozen_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm && !(wr_ctrl && bus_wdata[0]) && !srst) |=> (irq_norm && $stable(code_norm)));
    p_frozen_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fast && !(wr_ctrl && bus_wdata[1]) && !srst) |=> (irq_fast && $stable(code_fast)));
    p_rearm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[0]) |=> !irq_norm);
    p_gmask_norm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !irq_norm) |=> !irq_norm);
    p_gmask_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && !irq_fast) |=> !irq_fast);
    p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(code_norm) < NLINE) && (int'(code_fast) < NLINE));
    p_rev_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rev |=> (bus_rdata == {{(DATA_W-8){1'b0}}, REV}));
    p_status_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata == DATA_W'(1)));
    p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq_norm && !irq_fast));

endmodule

bind lic_ctrl lic_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .NLINE(NLINE), .REV(REV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast),
    .code_norm (code_norm),
    .code_fast (code_fast),
    .gmask     (gmask_q),
    .srst      (srst_q)
);

// File: tb/lic_ctrl_test.sv
// Directed bench for lic_ctrl: one task per scenario, each checking its own results.
module lic_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        tick(3);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[11:2];
        @(posedge clk);
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic drive_in(input logic [95:0] v);
        @(negedge clk);
        irq_in = v;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irq_norm low", {31'b0, irq_norm}, 32'h0);
        chk("R1 irq_fast low", {31'b0, irq_fast}, 32'h0);
        rd_chk("R1 mask bank0", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R1 mask bank1", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R1 mask bank2", 12'h0C4, 32'hFFFF_FFFF);
        rd_chk("R1 revision", 12'h000, 32'h21);
        rd_chk("R1 status", 12'h014, 32'h1);
        rd_chk("R1 swi bank0", 12'h090, 32'h0);
        rd_chk("R1 normal code", 12'h040, 32'h0);
    endtask

    task automatic t_level_pend();
        logic [95:0] v;
        do_reset();
        wr(12'h0A4, 32'h0);
        v = '0; v[40] = 1'b1;
        drive_in(v);
        rd_chk("R2 raw bank1", 12'h0A0, 32'h0000_0100);
        rd_chk("R2 normal view bank1", 12'h0B8, 32'h0000_0100);
        rd_chk("R2 fast view bank1", 12'h0BC, 32'h0);
        chk("R6 irq_norm raised", {31'b0, irq_norm}, 32'h1);
        rd_chk("R6 code line 40", 12'h040, 32'd40);
        wr(12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R2 view masked", 12'h0B8, 32'h0);
    endtask

    task automatic t_level_drop();
        logic [95:0] v;
        do_reset();
        wr(12'h084, 32'h0);
        wr(12'h090, 32'h8);
        v = '0; v[1] = 1'b1; v[2] = 1'b1;
        drive_in(v);
        rd_chk("R3 pending before drop", 12'h098, 32'hE);
        v[1] = 1'b0;
        drive_in(v);
        rd_chk("R3 pending after drop of line 1", 12'h098, 32'hC);
        v[2] = 1'b0;
        drive_in(v);
        rd_chk("R3 pending keeps software bit", 12'h098, 32'h8);
    endtask

    task automatic t_mask_alias();
        do_reset();
        wr(12'h0C8, 32'h0000_000F);
        rd_chk("R4 mask clear alias", 12'h0C4, 32'hFFFF_FFF0);
        wr(12'h0CC, 32'h0000_0003);
        rd_chk("R4 mask set alias", 12'h0C4, 32'hFFFF_FFF3);
        rd_chk("R4 clear alias reads 0", 12'h0C8, 32'h0);
        rd_chk("R4 set alias reads 0", 12'h0CC, 32'h0);
        wr(12'h0C4, 32'h1234_5678);
        rd_chk("R4 mask load", 12'h0C4, 32'h1234_5678);
    endtask

    task automatic t_swi();
        logic [95:0] v;
        do_reset();
        wr(12'h084, 32'h0);
        wr(12'h090, 32'h30);
        rd_chk("R5 software bits read", 12'h090, 32'h30);
        rd_chk("R5 software pending", 12'h098, 32'h30);
        v = '0; v[4] = 1'b1;
        drive_in(v);
        wr(12'h094, 32'h20);
        rd_chk("R5 software bits after clear", 12'h090, 32'h10);
        rd_chk("R5 pending = swi and inputs", 12'h098, 32'h10);
        wr(12'h094, 32'h10);
        rd_chk("R5 pending empty", 12'h098, 32'h0);
    endtask

    task automatic t_arb();
        logic [95:0] v;
        do_reset();
        wr(12'h084, 32'h0); wr(12'h0A4, 32'h0); wr(12'h0C4, 32'h0);
        wr(12'h100 + 12'd4*12'd10, 32'd3 << 2);
        wr(12'h100 + 12'd4*12'd70, 32'd3 << 2);
        wr(12'h100 + 12'd4*12'd33, 32'd5 << 2);
        v = '0; v[10] = 1'b1; v[70] = 1'b1; v[33] = 1'b1;
        drive_in(v);
        tick(1);
        chk("R6 irq_norm on tie", {31'b0, irq_norm}, 32'h1);
        rd_chk("R6 tie goes to higher line", 12'h040, 32'd70);
        wr(12'h100 + 12'd4*12'd10, 32'd1 << 2);
        wr(12'h048, 32'h1);
        chk("R7 rearm drops output", {31'b0, irq_norm}, 32'h0);
        tick(1);
        chk("R7 output back after rearm", {31'b0, irq_norm}, 32'h1);
        rd_chk("R6 lower priority value wins", 12'h040, 32'd10);
    endtask

    task automatic t_frozen();
        logic [95:0] v;
        do_reset();
        wr(12'h084, 32'h0);
        v = '0; v[7] = 1'b1;
        drive_in(v);
        tick(1);
        rd_chk("R7 first winner", 12'h040, 32'd7);
        v[20] = 1'b1;
        drive_in(v);
        tick(2);
        rd_chk("R7 code frozen", 12'h040, 32'd7);
        chk("R7 output held", {31'b0, irq_norm}, 32'h1);
        wr(12'h048, 32'h1);
        chk("R7 dropped at rearm", {31'b0, irq_norm}, 32'h0);
        tick(1);
        rd_chk("R7 new winner after rearm", 12'h040, 32'd20);
    endtask

    task automatic t_route();
        logic [95:0] v;
        do_reset();
        wr(12'h130, (32'd9 << 2) | 32'h3);
        rd_chk("R8 config readback", 12'h130, 32'h25);
        wr(12'h084, 32'h0);
        v = '0; v[12] = 1'b1;
        drive_in(v);
        tick(1);
        chk("R8 fast output", {31'b0, irq_fast}, 32'h1);
        chk("R8 normal output idle", {31'b0, irq_norm}, 32'h0);
        rd_chk("R8 fast code", 12'h044, 32'd12);
        rd_chk("R8 fast view", 12'h09C, 32'h0000_1000);
        rd_chk("R8 normal view empty", 12'h098, 32'h0);
    endtask

    task automatic t_gmask();
        logic [95:0] v;
        do_reset();
        wr(12'h048, 32'h4);
        rd_chk("R9 global mask reads back", 12'h048, 32'h4);
        wr(12'h084, 32'h0);
        v = '0; v[3] = 1'b1;
        drive_in(v);
        tick(3);
        chk("R9 output blocked", {31'b0, irq_norm}, 32'h0);
        wr(12'h048, 32'h0);
        tick(1);
        chk("R9 output after unmask", {31'b0, irq_norm}, 32'h1);
        rd_chk("R9 code after unmask", 12'h040, 32'd3);
    endtask

    task automatic t_bad_bank();
        do_reset();
        wr(12'h0E4, 32'h0);
        wr(12'h0E8, 32'hFFFF_FFFF);
        rd_chk("R10 bank 3 reads 0", 12'h0E4, 32'h0);
        rd_chk("R10 bank0 mask kept", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R10 bank1 mask kept", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R10 bank2 mask kept", 12'h0C4, 32'hFFFF_FFFF);
    endtask

    task automatic t_readonly();
        logic [95:0] v;
        do_reset();
        wr(12'h000, 32'h55);
        rd_chk("R11 revision kept", 12'h000, 32'h21);
        wr(12'h084, 32'h0);
        v = '0; v[9] = 1'b1;
        drive_in(v);
        tick(1);
        wr(12'h040, 32'h3);
        rd_chk("R11 code kept", 12'h040, 32'd9);
        wr(12'h080, 32'h0);
        rd_chk("R11 raw view kept", 12'h080, 32'h0000_0200);
        wr(12'h098, 32'h0);
        rd_chk("R11 pending view kept", 12'h098, 32'h0000_0200);
        wr(12'h014, 32'h0);
        rd_chk("R11 status kept", 12'h014, 32'h1);
    endtask

    task automatic t_sysconf();
        do_reset();
        wr(12'h010, 32'h1);
        rd_chk("R12 autoidle set", 12'h010, 32'h1);
        wr(12'h050, 32'h3);
        rd_chk("R12 idle field", 12'h050, 32'h3);
        wr(12'h050, 32'h6);
        rd_chk("R12 idle field width", 12'h050, 32'h2);
        rd_chk("R12 status done", 12'h014, 32'h1);
    endtask

    task automatic t_soft_reset();
        logic [95:0] v;
        do_reset();
        wr(12'h084, 32'h0);
        wr(12'h118, 32'd7 << 2);
        wr(12'h090, 32'h100);
        wr(12'h050, 32'h2);
        v = '0; v[6] = 1'b1;
        drive_in(v);
        tick(1);
        chk("R13 output before soft reset", {31'b0, irq_norm}, 32'h1);
        wr(12'h010, 32'h3);
        tick(1);
        chk("R13 output cleared", {31'b0, irq_norm}, 32'h0);
        rd_chk("R13 mask restored", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R13 software bits cleared", 12'h090, 32'h0);
        rd_chk("R13 line config cleared", 12'h118, 32'h0);
        rd_chk("R13 autoidle cleared", 12'h010, 32'h0);
        rd_chk("R13 idle cleared", 12'h050, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_level_pend();
        t_level_drop();
        t_mask_alias();
        t_swi();
        t_arb();
        t_frozen();
        t_route();
        t_gmask();
        t_bad_bank();
        t_readonly();
        t_sysconf();
        t_soft_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule